// File: doc/BRIEF.md
# Multi-Mode Amplitude Threshold Monitor

The block watches a stream of signed two's-complement converter samples, forms the magnitude of each qualified sample, and drives a status flag that reports how that magnitude stands against programmable limits. A mode input picks one of three policies:

- **Latch on exceed:** the flag sets on the first large sample and holds.
- **Set after dwell:** the flag sets after a run of small samples and holds.
- **Hysteresis:** the flag sets on a large sample and drops by itself after a run of samples under a lower limit.

The hysteresis policy suits gain-control loops. The two latching policies suit fault capture that software acknowledges.

Each run of small samples is counted by a dwell counter. Only cycles with the valid strobe high are evaluated. A single-cycle pulse accompanies every rising edge of the flag, so a downstream event collector can count occurrences without edge detection of its own.

Top module: `amp_level_watch`

## Requirements
- R1: While `rstN` is low and on the first cycle after it, `flagOut` and `setPulse` are 0.
- R2: Magnitude is the absolute value of `sampleData`. The most negative code (-2^(W-1)) is treated as 2^(W-1)-1. A sample counts as exceeding only when its magnitude is strictly greater than `upperThresh`.
- R3: With `modeSel` = 2'b00, a valid sample whose magnitude exceeds `upperThresh` sets `flagOut` at the next clock edge. The flag then holds through later samples of any size.
- R4: With `modeSel` = 2'b01, `flagOut` sets at the edge that takes the Nth consecutive valid sample with magnitude below `upperThresh`, where N = `dwellCount`. A `dwellCount` of 0 behaves as 1.
- R5: In modes 2'b00 and 2'b01 the flag clears only through `clearCmd` (effective at the next edge) or a mode change. A return of the signal to normal does not clear it.
- R6: With `modeSel` = 2'b10, `flagOut` sets on a valid sample that exceeds `upperThresh`. It clears by itself at the edge that takes the Nth consecutive valid sample with magnitude below `lowerThresh`.
- R7: A valid sample that does not meet the below-limit condition of the active mode restarts the consecutive count from zero. The count saturates instead of wrapping.
- R8: Cycles with `sampleValid` low neither advance nor restart the count, and they never set the flag.
- R9: A change of `modeSel` from one cycle to the next clears `flagOut` and the dwell count at the next edge. With `modeSel` = 2'b11 the flag stays 0.
- R10: `setPulse` is 1 for exactly the first cycle in which `flagOut` is 1 after having been 0.
- R11: When `clearCmd` coincides with a set condition, the flag ends up set. `clearCmd` also clears the flag in mode 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleData | input | SAMPLE_W | Signed converter sample |
| sampleValid | input | 1 | Sample qualifier |
| upperThresh | input | SAMPLE_W | Upper magnitude limit (unsigned) |
| lowerThresh | input | SAMPLE_W | Lower magnitude limit for hysteresis (unsigned) |
| dwellCount | input | DWELL_W | Consecutive-sample count required |
| modeSel | input | 2 | 00 latch-over, 01 dwell-under, 10 hysteresis, 11 off |
| clearCmd | input | 1 | Single-cycle flag clear request |
| flagOut | output | 1 | Threshold status flag |
| setPulse | output | 1 | One-cycle marker of a flag rise |

## Verification
Both `flagOut` and `setPulse` come from registers that take the current sample directly, so every result is due at the first rising edge after the stimulus is presented. A mode change or a clear also takes effect one edge later. The bench applies each stimulus on a falling edge and holds it for exactly one rising edge. It then reads the outputs on the following falling edge, half a period after they settle. For dwell behaviour the bench checks the flag after each sample of a run, so an off-by-one in the count shows up as a miscompare on a specific sample.

// File: rtl/amp_level_pkg.sv
package amp_level_pkg;

  typedef enum logic [1:0] {
    MODE_OVER  = 2'b00,
    MODE_UNDER = 2'b01,
    MODE_HYST  = 2'b10,
    MODE_OFF   = 2'b11
  } watchMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic evalEn;    // qualified sample this cycle
    logic restart;   // zero the dwell count
    logic useLower;  // below-test uses the lower limit
  } dwellCtl_t;

endpackage

// File: rtl/amp_level_mag.sv
module amp_level_mag #(
  parameter int SAMPLE_W = 16
) (
  input  logic [SAMPLE_W-1:0] sampleIn,
  output logic [SAMPLE_W-1:0] magOut
);
  localparam logic [SAMPLE_W-1:0] MAG_MAX = {1'b0, {(SAMPLE_W-1){1'b1}}};

  logic isNeg;
  logic isMinNeg;

  assign isNeg    = sampleIn[SAMPLE_W-1];
  assign isMinNeg = isNeg & ~(|sampleIn[SAMPLE_W-2:0]);

  always_comb begin
    if (isMinNeg)   magOut = MAG_MAX;
    else if (isNeg) magOut = (~sampleIn) + 1'b1;
    else            magOut = sampleIn;
  end
endmodule

// File: rtl/amp_level_dp.sv
module amp_level_dp
  import amp_level_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int DWELL_W  = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic [SAMPLE_W-1:0] upperThresh,
  input  logic [SAMPLE_W-1:0] lowerThresh,
  input  logic [DWELL_W-1:0]  dwellCount,
  input  dwellCtl_t           ctl,
  output logic                exceedHit,
  output logic                dwellHit
);
  logic [SAMPLE_W-1:0] magVal;
  logic [SAMPLE_W-1:0] belowLimit;
  logic                isBelow;
  logic [DWELL_W-1:0]  dwellCnt;
  logic [DWELL_W-1:0]  incCnt;

  amp_level_mag #(.SAMPLE_W(SAMPLE_W)) magUnit (
    .sampleIn (sampleData),
    .magOut   (magVal)
  );

  assign belowLimit = ctl.useLower ? lowerThresh : upperThresh;
  assign isBelow    = magVal < belowLimit;
  assign incCnt     = (&dwellCnt) ? dwellCnt : dwellCnt + 1'b1;

  assign exceedHit = ctl.evalEn & (magVal > upperThresh);
  assign dwellHit  = ctl.evalEn & isBelow & (incCnt >= dwellCount);

  always_ff @(posedge clk) begin
    if (!rstN || ctl.restart) begin
      dwellCnt <= '0;
    end else if (ctl.evalEn) begin
      dwellCnt <= isBelow ? incCnt : '0;
    end
  end
endmodule

// File: rtl/amp_level_ctrl.sv
module amp_level_ctrl
  import amp_level_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] modeSel,
  input  logic       sampleValid,
  input  logic       clearCmd,
  input  logic       exceedHit,
  input  logic       dwellHit,
  output dwellCtl_t  ctl,
  output logic       flagOut,
  output logic       setPulse
);
  watchMode_e modeNow;
  logic [1:0] modePrev;
  logic       modeChg;
  logic       setCond;
  logic       clrCond;
  logic       flagNext;

  assign modeNow = watchMode_e'(modeSel);
  assign modeChg = modeSel != modePrev;

  assign ctl.evalEn   = sampleValid & ~modeChg;
  assign ctl.restart  = modeChg;
  assign ctl.useLower = modeNow == MODE_HYST;

  always_comb begin
    unique case (modeNow)
      MODE_OVER:  setCond = exceedHit;
      MODE_UNDER: setCond = dwellHit;
      MODE_HYST:  setCond = exceedHit;
      default:    setCond = 1'b0;
    endcase
    clrCond = clearCmd | ((modeNow == MODE_HYST) & flagOut & dwellHit);
    if (modeChg || modeNow == MODE_OFF) flagNext = 1'b0;
    else if (setCond)                   flagNext = 1'b1;
    else if (clrCond)                   flagNext = 1'b0;
    else                                flagNext = flagOut;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modePrev <= modeSel;
      flagOut  <= 1'b0;
      setPulse <= 1'b0;
    end else begin
      modePrev <= modeSel;
      flagOut  <= flagNext;
      setPulse <= flagNext & ~flagOut;
    end
  end
endmodule

// File: rtl/amp_level_watch.sv
module amp_level_watch
  import amp_level_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int DWELL_W  = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] upperThresh,
  input  logic [SAMPLE_W-1:0] lowerThresh,
  input  logic [DWELL_W-1:0]  dwellCount,
  input  logic [1:0]          modeSel,
  input  logic                clearCmd,
  output logic                flagOut,
  output logic                setPulse
);
  dwellCtl_t ctl;
  logic      exceedHit;
  logic      dwellHit;

  amp_level_dp #(.SAMPLE_W(SAMPLE_W), .DWELL_W(DWELL_W)) dpUnit (
    .clk         (clk),
    .rstN        (rstN),
    .sampleData  (sampleData),
    .upperThresh (upperThresh),
    .lowerThresh (lowerThresh),
    .dwellCount  (dwellCount),
    .ctl         (ctl),
    .exceedHit   (exceedHit),
    .dwellHit    (dwellHit)
  );

  amp_level_ctrl ctrlUnit (
    .clk         (clk),
    .rstN        (rstN),
    .modeSel     (modeSel),
    .sampleValid (sampleValid),
    .clearCmd    (clearCmd),
    .exceedHit   (exceedHit),
    .dwellHit    (dwellHit),
    .ctl         (ctl),
    .flagOut     (flagOut),
    .setPulse    (setPulse)
  );
endmodule

// File: rtl/amp_level_watch_chk.sv
module amp_level_watch_chk #(
  parameter int SAMPLE_W = 16,
  parameter int DWELL_W  = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic [SAMPLE_W-1:0] sampleData,
  input logic                sampleValid,
  input logic [SAMPLE_W-1:0] upperThresh,
  input logic [SAMPLE_W-1:0] lowerThresh,
  input logic [DWELL_W-1:0]  dwellCount,
  input logic [1:0]          modeSel,
  input logic                clearCmd,
  input logic                flagOut,
  input logic                setPulse
);
  logic [SAMPLE_W-1:0] refMag;
  always_comb begin
    if (sampleData == {1'b1, {(SAMPLE_W-1){1'b0}}})
      refMag = {1'b0, {(SAMPLE_W-1){1'b1}}};
    else if (sampleData[SAMPLE_W-1])
      refMag = -sampleData;
    else
      refMag = sampleData;
  end

  // R10
  pulse_marks_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    setPulse |-> (flagOut && !$past(flagOut)));

  // R8
  rise_needs_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagOut) |-> $past(sampleValid));

  // R9
  mode_change_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel != $past(modeSel)) |=> !flagOut);

  // R9
  off_mode_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(modeSel) == 2'b11) |-> !flagOut);

  // R3
  over_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'b00 && $past(modeSel) == 2'b00 && sampleValid && refMag > upperThresh)
      |=> flagOut);

  // R5
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(flagOut) && $past(modeSel) != 2'b10) |->
      ($past(clearCmd) || $past(modeSel) != $past(modeSel, 2)));
endmodule

bind amp_level_watch amp_level_watch_chk #(.SAMPLE_W(SAMPLE_W), .DWELL_W(DWELL_W)) chkInst (
  .clk(clk), .rstN(rstN), .sampleData(sampleData), .sampleValid(sampleValid),
  .upperThresh(upperThresh), .lowerThresh(lowerThresh), .dwellCount(dwellCount),
  .modeSel(modeSel), .clearCmd(clearCmd), .flagOut(flagOut), .setPulse(setPulse)
);

// File: tb/amp_level_watch_test.sv
`timescale 1ns/1ps
module amp_level_watch_test;
  localparam int SW = 16;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [SW-1:0] sampleData = '0;
  logic          sampleValid = 1'b0;
  logic [SW-1:0] upperThresh = 16'd1000;
  logic [SW-1:0] lowerThresh = 16'd200;
  logic [DW-1:0] dwellCount = 16'd3;
  logic [1:0]    modeSel = 2'b00;
  logic          clearCmd = 1'b0;
  logic          flagOut;
  logic          setPulse;

  int applied = 0;
  int failed  = 0;

  always #5 clk = ~clk;

  amp_level_watch #(.SAMPLE_W(SW), .DWELL_W(DW)) uut (
    .clk(clk), .rstN(rstN), .sampleData(sampleData), .sampleValid(sampleValid),
    .upperThresh(upperThresh), .lowerThresh(lowerThresh), .dwellCount(dwellCount),
    .modeSel(modeSel), .clearCmd(clearCmd), .flagOut(flagOut), .setPulse(setPulse)
  );

  task automatic check(input string req, input logic act, input logic exp);
    applied++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // present one cycle of stimulus, then read results half a period after the edge
  task automatic step(input logic signed [SW-1:0] s, input logic v, input logic c);
    sampleData  = s;
    sampleValid = v;
    clearCmd    = c;
    @(negedge clk);
    sampleValid = 1'b0;
    clearCmd    = 1'b0;
  endtask

  task automatic enter_mode(input logic [1:0] m);
    modeSel = m;
    step(0, 1'b0, 1'b1);
    step(0, 1'b0, 1'b0);
  endtask

  task automatic t_reset();
    check("R1 flag in reset", flagOut, 1'b0);
    check("R1 pulse in reset", setPulse, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 flag after reset", flagOut, 1'b0);
    check("R1 pulse after reset", setPulse, 1'b0);
  endtask

  task automatic t_over();
    enter_mode(2'b00);
    step(16'sd1000, 1'b1, 1'b0);
    check("R2 equal to upper is not exceed", flagOut, 1'b0);
    step(-16'sd1001, 1'b1, 1'b0);
    check("R3 negative exceed sets", flagOut, 1'b1);
    check("R10 pulse on rise", setPulse, 1'b1);
    step(16'sd5, 1'b1, 1'b0);
    check("R3 flag holds", flagOut, 1'b1);
    check("R10 pulse one cycle", setPulse, 1'b0);
    step(16'sd5, 1'b1, 1'b1);
    check("R5 clear drops flag", flagOut, 1'b0);
  endtask

  task automatic t_minneg();
    upperThresh = 16'd32766;
    enter_mode(2'b00);
    step(16'sh8000, 1'b1, 1'b0);
    check("R2 most negative saturates and exceeds", flagOut, 1'b1);
    upperThresh = 16'd32767;
    step(0, 1'b0, 1'b1);
    step(16'sh8000, 1'b1, 1'b0);
    check("R2 saturated magnitude not above max", flagOut, 1'b0);
    upperThresh = 16'd1000;
  endtask

  task automatic t_under();
    enter_mode(2'b01);
    step(16'sd50, 1'b1, 1'b0);
    step(-16'sd50, 1'b1, 1'b0);
    check("R4 two of three not enough", flagOut, 1'b0);
    step(16'sd5000, 1'b0, 1'b0);
    step(16'sd5000, 1'b0, 1'b0);
    check("R8 idle cycles do not restart", flagOut, 1'b0);
    step(16'sd50, 1'b1, 1'b0);
    check("R4 third below sets", flagOut, 1'b1);
    step(16'sd5000, 1'b1, 1'b0);
    step(16'sd5000, 1'b1, 1'b0);
    check("R5 recovery keeps flag", flagOut, 1'b1);
    step(0, 1'b0, 1'b1);
    check("R5 clear releases", flagOut, 1'b0);
    step(16'sd50, 1'b1, 1'b0);
    step(16'sd50, 1'b1, 1'b0);
    step(16'sd1200, 1'b1, 1'b0);
    step(16'sd50, 1'b1, 1'b0);
    step(16'sd50, 1'b1, 1'b0);
    check("R7 run restarted", flagOut, 1'b0);
    step(16'sd50, 1'b1, 1'b0);
    check("R7 third after restart sets", flagOut, 1'b1);
    dwellCount = 16'd0;
    step(0, 1'b0, 1'b1);
    step(16'sd50, 1'b1, 1'b0);
    check("R4 dwell zero acts as one", flagOut, 1'b1);
    dwellCount = 16'd3;
  endtask

  task automatic t_hyst();
    enter_mode(2'b10);
    step(16'sd1500, 1'b1, 1'b0);
    check("R6 exceed sets", flagOut, 1'b1);
    step(16'sd100, 1'b1, 1'b0);
    step(16'sd100, 1'b1, 1'b0);
    step(16'sd500, 1'b1, 1'b0);
    step(16'sd100, 1'b1, 1'b0);
    step(16'sd100, 1'b1, 1'b0);
    check("R7 mid sample restarted count", flagOut, 1'b1);
    step(16'sd100, 1'b1, 1'b0);
    check("R6 self clear after dwell", flagOut, 1'b0);
    step(16'sd1500, 1'b1, 1'b0);
    step(0, 1'b0, 1'b1);
    check("R11 clear works in hysteresis", flagOut, 1'b0);
  endtask

  task automatic t_priority();
    enter_mode(2'b00);
    step(16'sd2000, 1'b1, 1'b1);
    check("R11 set wins from low", flagOut, 1'b1);
    check("R10 pulse with clear present", setPulse, 1'b1);
    step(16'sd2000, 1'b1, 1'b1);
    check("R11 set wins while high", flagOut, 1'b1);
    check("R10 no pulse while already high", setPulse, 1'b0);
  endtask

  task automatic t_mode();
    enter_mode(2'b00);
    step(16'sd2000, 1'b1, 1'b0);
    check("R9 precondition flag set", flagOut, 1'b1);
    modeSel = 2'b10;
    step(0, 1'b0, 1'b0);
    check("R9 mode change clears", flagOut, 1'b0);
    modeSel = 2'b11;
    step(0, 1'b0, 1'b0);
    step(16'sd5000, 1'b1, 1'b0);
    check("R9 off mode stays low", flagOut, 1'b0);
    // dwell count cleared by mode change: two belows before, switch, two after
    enter_mode(2'b01);
    step(16'sd50, 1'b1, 1'b0);
    step(16'sd50, 1'b1, 1'b0);
    modeSel = 2'b00;
    step(0, 1'b0, 1'b0);
    modeSel = 2'b01;
    step(0, 1'b0, 1'b0);
    step(16'sd50, 1'b1, 1'b0);
    check("R9 count cleared by mode change", flagOut, 1'b0);
    step(16'sd50, 1'b1, 1'b0);
    check("R9 count cleared by mode change", flagOut, 1'b0);
    step(16'sd50, 1'b1, 1'b0);
    check("R4 fresh run sets", flagOut, 1'b1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", applied, failed);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_over();
    t_minneg();
    t_under();
    t_hyst();
    t_priority();
    t_mode();
    $display("== %0d vectors applied, %0d miscompares ==", applied, failed);
    $finish;
  end
endmodule